// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block reads a run of consecutive bytes from a serial EEPROM over a four-wire link. The link has a serial clock, a data line towards the memory, a data line from the memory, and two access-control lines. A requester presents a 16-bit start offset, a byte count and a phase length, and pulses start for one cycle. The sequencer opens access with an ordered two-step handshake. It then shifts out a read command and the two offset bytes, and shifts in the requested number of bytes. Each byte is handed to the requester on a one-cycle valid strobe. Access is then closed with the reverse two-step handshake, and a one-cycle done pulse follows.

Every step on the link (an access-line change, a data setup, a clock high or a clock low) is held for a programmable number of system cycles. The memory advances its own address after each byte, so one command and one address are enough for any number of bytes.

Top module: `eeprom_rd_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o and byte_valid_o are 0, ee_sclk_o and ee_mosi_o are 0, ee_acc_hi_o is 0 and ee_acc_lo_o is 1.
- R2: Access opens in two separate steps: ee_acc_hi_o rises first, and ee_acc_lo_o falls in a later cycle. ee_sclk_o is high only while ee_acc_hi_o is 1 and ee_acc_lo_o is 0.
- R3: After access opens, 24 bits go out, most significant bit first: the command 0x03, then offset bits 15:8, then offset bits 7:0. Each bit is placed on ee_mosi_o in a step of its own before ee_sclk_o rises, and it stays unchanged while ee_sclk_o is high.
- R4: Input bits are sampled from ee_miso_i while ee_sclk_o is high and are shifted in at the least significant end, so the first bit received becomes bit 7. Each byte appears on byte_o together with a single-cycle byte_valid_o pulse. Byte i holds the memory content at address offset+i, modulo 2^16.
- R5: Exactly count_i bytes are delivered per request. With count_i = 0 the handshakes, command and address still run, and no byte is delivered.
- R6: ee_mosi_o is 0 throughout the data-input phase.
- R7: After every transfer, access closes in two separate steps: ee_acc_lo_o rises first, and ee_acc_hi_o falls in a later cycle. The link ends with ee_sclk_o at 0.
- R8: Every level of ee_sclk_o lasts at least half_period_i + 1 system cycles.
- R9: A start pulse while busy_o is 1 has no effect. done_o is a single-cycle pulse that comes after the close handshake, and in that cycle busy_o is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request pulse, taken only when idle |
| offset_i | input | 16 | Start address in the memory |
| count_i | input | CNT_W | Number of bytes to read |
| half_period_i | input | DIV_W | Extra cycles added to each link step (step length is this value + 1) |
| busy_o | output | 1 | High from the accepted start until done |
| done_o | output | 1 | One-cycle pulse when the transfer is fully closed |
| byte_valid_o | output | 1 | One-cycle strobe marking a received byte |
| byte_o | output | 8 | Received byte, valid with byte_valid_o |
| ee_sclk_o | output | 1 | Serial clock to the memory, rests low |
| ee_mosi_o | output | 1 | Serial data to the memory |
| ee_miso_i | input | 1 | Serial data from the memory |
| ee_acc_hi_o | output | 1 | High-side access-control line |
| ee_acc_lo_o | output | 1 | Low-side access-control line |

## Verification
The read path is driven with random offsets, random counts from 0 to 6 and random step lengths. Directed cases add a zero-byte request, a request whose addresses wrap past 0xFFFF, and the shortest possible step length. Random offsets separate correct high and low address ordering from swapped or mis-shifted headers. The wrap case and multi-byte runs show that the memory address advances implicitly and that the byte order is most significant bit first. A start pulse injected in the middle of a transfer, carrying a different offset, must leave the data, the header count and the done count unchanged. The step-length patterns show whether each clock level is held long enough.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    localparam logic [7:0] READ_CMD   = 8'h03;
    localparam int         HDR_BYTES  = 3;

    // one link step per state; each lasts (hold + 1) system cycles
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EN_HI,
        ST_EN_LO,
        ST_TX_SET,
        ST_TX_HI,
        ST_TX_LO,
        ST_RX_HI,
        ST_RX_LO,
        ST_DIS_LO,
        ST_DIS_HI
    } step_e;

    typedef enum logic [1:0] {
        SH_HOLD,
        SH_LOAD,
        SH_OUT,
        SH_IN
    } shift_op_e;

    typedef struct packed {
        logic sclk;
        logic mosi;
        logic acc_hi;
        logic acc_lo;
    } pads_t;

    localparam pads_t PADS_REST = '{sclk: 1'b0, mosi: 1'b0, acc_hi: 1'b0, acc_lo: 1'b1};

    // header byte by position: command, address high, address low
    function automatic logic [7:0] hdr_byte(input logic [1:0] idx, input logic [15:0] addr);
        case (idx)
            2'd0:    return READ_CMD;
            2'd1:    return addr[15:8];
            default: return addr[7:0];
        endcase
    endfunction

endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [DIV_W-1:0] hold_i,
    output logic             expire_o
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= hold_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/ee_byte_shifter.sv
module ee_byte_shifter
    import eeprom_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  shift_op_e  op_i,
    input  logic [7:0] load_i,
    input  logic       bit_i,
    output logic [7:0] byte_o
);

    logic [7:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            case (op_i)
                SH_LOAD: sh_q <= load_i;
                SH_OUT:  sh_q <= {sh_q[6:0], 1'b0};
                SH_IN:   sh_q <= {sh_q[6:0], bit_i};
                default: sh_q <= sh_q;
            endcase
        end
    end

    assign byte_o = sh_q;

endmodule

// File: rtl/ee_step_ctrl.sv
module ee_step_ctrl
    import eeprom_rd_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [15:0]      offset_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [DIV_W-1:0] half_period_i,
    input  logic             expire_i,
    input  logic [7:0]       sh_byte_i,
    output logic             tmr_load_o,
    output logic [DIV_W-1:0] tmr_hold_o,
    output shift_op_e        sh_op_o,
    output logic [7:0]       sh_load_o,
    output pads_t            pads_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             byte_valid_o,
    output logic [7:0]       byte_o
);

    localparam logic [1:0] LAST_HDR = 2'(HDR_BYTES - 1);

    step_e            st_q;
    logic [DIV_W-1:0] hold_q;
    logic [15:0]      off_q;
    logic [CNT_W-1:0] rem_q;
    logic [1:0]       hdr_q;
    logic [2:0]       bit_q;
    pads_t            pads_q;
    logic             done_q;
    logic             vld_q;
    logic [7:0]       byte_q;
    logic             adv;

    assign adv        = (st_q != ST_IDLE) && expire_i;
    assign tmr_load_o = ((st_q == ST_IDLE) && start_i) || adv;
    assign tmr_hold_o = (st_q == ST_IDLE) ? half_period_i : hold_q;

    // shifter command for the edge that ends the current step
    always_comb begin
        sh_op_o   = SH_HOLD;
        sh_load_o = hdr_byte(2'd0, off_q);
        case (st_q)
            ST_EN_LO: if (adv) sh_op_o = SH_LOAD;
            ST_TX_LO: begin
                if (adv) begin
                    if (bit_q != 3'd0) begin
                        sh_op_o = SH_OUT;
                    end else if (hdr_q != LAST_HDR) begin
                        sh_op_o   = SH_LOAD;
                        sh_load_o = hdr_byte(hdr_q + 2'd1, off_q);
                    end
                end
            end
            ST_RX_HI: if (adv) sh_op_o = SH_IN;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
            off_q  <= '0;
            rem_q  <= '0;
            hdr_q  <= '0;
            bit_q  <= '0;
            pads_q <= PADS_REST;
            done_q <= 1'b0;
            vld_q  <= 1'b0;
            byte_q <= '0;
        end else begin
            done_q <= 1'b0;
            vld_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        hold_q        <= half_period_i;
                        off_q         <= offset_i;
                        rem_q         <= count_i;
                        pads_q.acc_hi <= 1'b1;
                        st_q          <= ST_EN_HI;
                    end
                end
                ST_EN_HI: begin
                    if (adv) begin
                        pads_q.acc_lo <= 1'b0;
                        st_q          <= ST_EN_LO;
                    end
                end
                ST_EN_LO: begin
                    if (adv) begin
                        hdr_q       <= 2'd0;
                        bit_q       <= 3'd7;
                        pads_q.mosi <= READ_CMD[7];
                        st_q        <= ST_TX_SET;
                    end
                end
                ST_TX_SET: begin
                    if (adv) begin
                        pads_q.sclk <= 1'b1;
                        st_q        <= ST_TX_HI;
                    end
                end
                ST_TX_HI: begin
                    if (adv) begin
                        pads_q.sclk <= 1'b0;
                        // release the data line with the falling edge of the last header bit
                        if (hdr_q == LAST_HDR && bit_q == 3'd0) begin
                            pads_q.mosi <= 1'b0;
                        end
                        st_q <= ST_TX_LO;
                    end
                end
                ST_TX_LO: begin
                    if (adv) begin
                        if (bit_q != 3'd0) begin
                            bit_q       <= bit_q - 3'd1;
                            pads_q.mosi <= sh_byte_i[6];
                            st_q        <= ST_TX_SET;
                        end else if (hdr_q != LAST_HDR) begin
                            hdr_q       <= hdr_q + 2'd1;
                            bit_q       <= 3'd7;
                            pads_q.mosi <= sh_load_o[7];
                            st_q        <= ST_TX_SET;
                        end else if (rem_q != '0) begin
                            bit_q       <= 3'd7;
                            pads_q.sclk <= 1'b1;
                            st_q        <= ST_RX_HI;
                        end else begin
                            pads_q.acc_lo <= 1'b1;
                            st_q          <= ST_DIS_LO;
                        end
                    end
                end
                ST_RX_HI: begin
                    if (adv) begin
                        pads_q.sclk <= 1'b0;
                        st_q        <= ST_RX_LO;
                    end
                end
                ST_RX_LO: begin
                    if (adv) begin
                        if (bit_q != 3'd0) begin
                            bit_q       <= bit_q - 3'd1;
                            pads_q.sclk <= 1'b1;
                            st_q        <= ST_RX_HI;
                        end else begin
                            vld_q  <= 1'b1;
                            byte_q <= sh_byte_i;
                            rem_q  <= rem_q - 1'b1;
                            if (rem_q != CNT_W'(1)) begin
                                bit_q       <= 3'd7;
                                pads_q.sclk <= 1'b1;
                                st_q        <= ST_RX_HI;
                            end else begin
                                pads_q.acc_lo <= 1'b1;
                                st_q          <= ST_DIS_LO;
                            end
                        end
                    end
                end
                ST_DIS_LO: begin
                    if (adv) begin
                        pads_q.acc_hi <= 1'b0;
                        st_q          <= ST_DIS_HI;
                    end
                end
                ST_DIS_HI: begin
                    if (adv) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign pads_o       = pads_q;
    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = done_q;
    assign byte_valid_o = vld_q;
    assign byte_o       = byte_q;

endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
    import eeprom_rd_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [15:0]      offset_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [DIV_W-1:0] half_period_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             byte_valid_o,
    output logic [7:0]       byte_o,
    output logic             ee_sclk_o,
    output logic             ee_mosi_o,
    input  logic             ee_miso_i,
    output logic             ee_acc_hi_o,
    output logic             ee_acc_lo_o
);

    logic             tmr_load;
    logic [DIV_W-1:0] tmr_hold;
    logic             tmr_expire;
    shift_op_e        sh_op;
    logic [7:0]       sh_load;
    logic [7:0]       sh_byte;
    pads_t            pads;

    ee_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (tmr_load),
        .hold_i   (tmr_hold),
        .expire_o (tmr_expire)
    );

    ee_byte_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .op_i   (sh_op),
        .load_i (sh_load),
        .bit_i  (ee_miso_i),
        .byte_o (sh_byte)
    );

    ee_step_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .offset_i      (offset_i),
        .count_i       (count_i),
        .half_period_i (half_period_i),
        .expire_i      (tmr_expire),
        .sh_byte_i     (sh_byte),
        .tmr_load_o    (tmr_load),
        .tmr_hold_o    (tmr_hold),
        .sh_op_o       (sh_op),
        .sh_load_o     (sh_load),
        .pads_o        (pads),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .byte_valid_o  (byte_valid_o),
        .byte_o        (byte_o)
    );

    assign ee_sclk_o   = pads.sclk;
    assign ee_mosi_o   = pads.mosi;
    assign ee_acc_hi_o = pads.acc_hi;
    assign ee_acc_lo_o = pads.acc_lo;

endmodule

// File: rtl/eeprom_rd_seq_chk.sv
module eeprom_rd_seq_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] half_period_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             byte_valid_o,
    input logic             ee_sclk_o,
    input logic             ee_mosi_o,
    input logic             ee_acc_hi_o,
    input logic             ee_acc_lo_o
);

    localparam int RUN_W = DIV_W + 2;

    logic [RUN_W-1:0] run_len;
    logic             sclk_prev;

    // length of the current ee_sclk_o level in cycles, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= '1;
            sclk_prev <= 1'b0;
        end else if (ee_sclk_o != sclk_prev) begin
            run_len   <= RUN_W'(1);
            sclk_prev <= ee_sclk_o;
        end else if (run_len != '1) begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_sclk_gated_R2: assert property (@(posedge clk) disable iff (rst)
        ee_sclk_o |-> (ee_acc_hi_o && !ee_acc_lo_o));

    assert_open_order_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ee_acc_lo_o) |-> $past(ee_acc_hi_o));

    assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (rst)
        ee_sclk_o |-> $stable(ee_mosi_o));

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> !byte_valid_o);

    assert_mosi_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> !ee_mosi_o);

    assert_close_order_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ee_acc_hi_o) |-> $past(ee_acc_lo_o));

    assert_phase_len_R8: assert property (@(posedge clk) disable iff (rst)
        (ee_sclk_o != sclk_prev) |-> (run_len > RUN_W'(half_period_i)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_closed_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && ee_acc_lo_o && !ee_acc_hi_o && !ee_sclk_o));

endmodule

bind eeprom_rd_seq eeprom_rd_seq_chk #(.DIV_W(DIV_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .half_period_i (half_period_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .byte_valid_o  (byte_valid_o),
    .ee_sclk_o     (ee_sclk_o),
    .ee_mosi_o     (ee_mosi_o),
    .ee_acc_hi_o   (ee_acc_hi_o),
    .ee_acc_lo_o   (ee_acc_lo_o)
);

// File: tb/sim_eeprom_rd_seq.sv
module sim_eeprom_rd_seq;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CNT_W = 8;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [15:0]      offset_i = '0;
    logic [CNT_W-1:0] count_i = '0;
    logic [DIV_W-1:0] half_period_i = '0;
    logic             busy_o, done_o, byte_valid_o;
    logic [7:0]       byte_o;
    logic             ee_sclk_o, ee_mosi_o, ee_acc_hi_o, ee_acc_lo_o;
    logic             ee_miso_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit wd     = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_rd_seq #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u0 (
        .clk, .rst, .start_i, .offset_i, .count_i, .half_period_i,
        .busy_o, .done_o, .byte_valid_o, .byte_o,
        .ee_sclk_o, .ee_mosi_o, .ee_miso_i, .ee_acc_hi_o, .ee_acc_lo_o
    );

    // memory content as a function of address
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
    endfunction

    // ---------------- behavioural memory ----------------
    logic        open_w;
    int          hdr_n = 0;
    int          k = 0;
    int          hdr_total = 0;
    logic [23:0] hdr = '0;
    assign open_w = ee_acc_hi_o && !ee_acc_lo_o;

    always @(posedge ee_sclk_o) begin
        if (open_w && hdr_n < 24) begin
            hdr   = {hdr[22:0], ee_mosi_o};
            hdr_n = hdr_n + 1;
            if (hdr_n == 24) hdr_total = hdr_total + 1;
        end
    end

    always @(negedge ee_sclk_o) begin
        logic [15:0] a;
        logic [7:0]  d;
        if (open_w && hdr_n == 24) begin
            a = hdr[15:0] + 16'(k / 8);
            d = mem_byte(a);
            ee_miso_i <= d[7 - (k % 8)];
            k = k + 1;
        end
    end

    always @(posedge clk) begin
        if (!open_w) begin
            hdr_n = 0;
            k     = 0;
        end
    end

    // ---------------- monitors (sampled at the falling system edge) ----------------
    logic [7:0] got [256];
    int  ngot = 0;
    int  done_cnt = 0;
    int  order_bad = 0;
    int  mosi_bad = 0;
    int  run = 0;
    int  min_hi = 1000000;
    int  min_lo = 1000000;
    logic prev_s = 1'b0, prev_hi = 1'b0, prev_lo = 1'b1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !wd) begin
            wd    = 1'b1;
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
        end
        if (!rst) begin
            if (byte_valid_o) begin
                got[ngot[7:0]] = byte_o;
                ngot = ngot + 1;
            end
            if (done_o) done_cnt = done_cnt + 1;
            if (ee_acc_lo_o == 1'b0 && prev_lo == 1'b1 && prev_hi == 1'b0) order_bad = order_bad + 1;
            if (ee_acc_hi_o == 1'b0 && prev_hi == 1'b1 && prev_lo == 1'b0) order_bad = order_bad + 1;
            if (ee_sclk_o && !open_w) order_bad = order_bad + 1;
            if (open_w && hdr_n == 24 && k > 0 && ee_mosi_o) mosi_bad = mosi_bad + 1;
            if (ee_sclk_o == prev_s) begin
                run = run + 1;
            end else begin
                if (prev_s) begin
                    if (run < min_hi) min_hi = run;
                end else begin
                    if (run < min_lo) min_lo = run;
                end
                run = 1;
            end
        end
        prev_s  = ee_sclk_o;
        prev_hi = ee_acc_hi_o;
        prev_lo = ee_acc_lo_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [15:0] off, input int cnt, input int hp, input bit poke);
        int d0, h0;
        d0 = done_cnt;
        h0 = hdr_total;
        ngot = 0; order_bad = 0; mosi_bad = 0;
        min_hi = 1000000; min_lo = 1000000;
        @(negedge clk);
        offset_i      = off;
        count_i       = CNT_W'(cnt);
        half_period_i = DIV_W'(hp);
        start_i       = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9", "busy after start", 32'(busy_o), 1);
        if (poke) begin
            repeat (40 * (hp + 1)) @(negedge clk);
            offset_i = ~off;
            count_i  = CNT_W'(cnt + 3);
            start_i  = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_cnt == d0 && !wd) @(negedge clk);
        repeat (30) @(negedge clk);
        check(done_cnt == d0 + 1, "R9", "done pulse count", 32'(done_cnt - d0), 1);
        check(hdr_total == h0 + 1, "R9", "headers seen", 32'(hdr_total - h0), 1);
        check(busy_o == 1'b0, "R9", "busy after done", 32'(busy_o), 0);
        check(hdr == {8'h03, off}, "R3", "command and address", 32'(hdr), 32'({8'h03, off}));
        check(ngot == cnt, "R5", "bytes delivered", 32'(ngot), 32'(cnt));
        for (int i = 0; i < cnt && i < ngot; i++) begin
            logic [7:0] e;
            e = mem_byte(off + 16'(i));
            check(got[i] == e, "R4", "data byte", 32'(got[i]), 32'(e));
        end
        check(order_bad == 0, "R2_R7", "access ordering violations", 32'(order_bad), 0);
        check(ee_acc_hi_o == 1'b0 && ee_acc_lo_o == 1'b1 && ee_sclk_o == 1'b0, "R7",
              "closed link {hi,lo,sclk}", 32'({ee_acc_hi_o, ee_acc_lo_o, ee_sclk_o}), 32'b010);
        check(mosi_bad == 0, "R6", "data line high while reading", 32'(mosi_bad), 0);
        check(min_hi >= hp + 1, "R8", "shortest clock high", 32'(min_hi), 32'(hp + 1));
        check(min_lo >= hp + 1, "R8", "shortest clock low", 32'(min_lo), 32'(hp + 1));
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({busy_o, done_o, byte_valid_o} == 3'b000, "R1", "status after reset",
              32'({busy_o, done_o, byte_valid_o}), 0);
        check({ee_sclk_o, ee_mosi_o, ee_acc_hi_o, ee_acc_lo_o} == 4'b0001, "R1", "link after reset",
              32'({ee_sclk_o, ee_mosi_o, ee_acc_hi_o, ee_acc_lo_o}), 1);

        // directed corners
        run_xfer(16'h1234, 3, 1, 1'b0);   // R3 R4 basic
        run_xfer(16'h0040, 0, 2, 1'b0);   // R5 zero bytes
        run_xfer(16'hFFFE, 4, 0, 1'b0);   // R4 address wrap, shortest step
        run_xfer(16'hA55A, 5, 3, 1'b1);   // R9 start while busy ignored

        // constrained random
        for (int t = 0; t < 12 && !wd; t++) begin
            logic [15:0] o;
            int c, h;
            o = 16'($urandom);
            c = int'($urandom % 7);
            h = int'($urandom % 4);
            run_xfer(o, c, h, ($urandom % 4) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (wd);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule